// File: doc/BRIEF.md
# Configurable Metering Element Accumulator

This block integrates per-sample power and current-squared quantities for an energy meter front end. Each time the sample strobe is high, the block takes four signed 16-bit samples: two voltages (VA, VB) and two currents (IA, IB). A 2-bit equation code, read on the same strobe, sets how these samples form two element products, two current-squared terms and a total-power term. Each of the five quantities is added into its own 48-bit accumulator.

An interval-length input sets how many strobed samples make up one accumulation interval. On the strobe that completes the interval, the block latches the five totals into output registers. That latched total includes the closing sample. A one-cycle valid pulse marks the new totals, and the accumulators restart from zero for the next sample. Downstream logic reads the latched totals at its leisure until the next pulse.

Top module: `metering_accum`

## Requirements
- R1: After reset, all five sum outputs are zero and `sum_valid_o` is low.
- R2: With equation code 0, the terms are: element 0 = VA*IA, element 1 = VA*IB, current-squared 0 = IA², current-squared 1 = IB².
- R3: With equation code 1, the terms are: element 0 = (VA*(IA-IB)) >>> 1, element 1 = (VA*IB) >>> 1, current-squared 0 = (IA-IB)², current-squared 1 = IB². Halving is an arithmetic shift of the full product, so it rounds toward minus infinity.
- R4: With equation code 2, the terms are: element 0 = VA*IA, element 1 = VB*IB, current-squared 0 = IA², current-squared 1 = IB².
- R5: Equation code 3 gives the same terms as code 0.
- R6: The total-power term is element 0 + element 1 under code 2. Under every other code it is element 0 alone.
- R7: The interval closes on the strobe that brings the sample count up to the interval length. On the following clock edge, the outputs hold the sums including that sample and `sum_valid_o` is high for exactly that one cycle. The next strobed sample begins a fresh sum.
- R8: Cycles without a strobe change neither the sums nor the sample count.
- R9: Between valid pulses, the latched sum outputs hold their values.
- R10: An interval length of 0 acts as 1. If the length is lowered below the count already reached, the next strobe closes the interval.
- R11: The IA-IB difference is formed at 17 bits without wrap. The current-squared terms are never negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample strobe |
| va_i | input | 16 | Voltage A sample, signed |
| vb_i | input | 16 | Voltage B sample, signed |
| ia_i | input | 16 | Current A sample, signed |
| ib_i | input | 16 | Current B sample, signed |
| eq_sel_i | input | 2 | Equation code: 0 one element, 1 halved differential, 2 two element, 3 as 0 |
| interval_len_i | input | 16 | Samples per interval (0 acts as 1) |
| elem0_sum_o | output | 48 | Latched element 0 total, signed |
| elem1_sum_o | output | 48 | Latched element 1 total, signed |
| isq0_sum_o | output | 48 | Latched current-squared 0 total |
| isq1_sum_o | output | 48 | Latched current-squared 1 total |
| power_sum_o | output | 48 | Latched total-power total, signed |
| sum_valid_o | output | 1 | One-cycle pulse when new totals are latched |

## Verification
The bench drives full-scale samples in the differential mode, where IA-IB reaches 65535. A design that forms the difference at 16 bits would wrap it to a negative value and report a wrong element and current-squared total. Negative odd products check that halving rounds toward minus infinity; a truncating divide would be off by one. The equation code changes sample by sample within an interval, which exposes a design that routes by a stale code or misroutes code 3. Interval lengths of 0 and 1 are tested, and so is a length lowered mid-interval. Both catch counters that compare for equality and then run past the end. Random strobe gaps catch a design that counts idle cycles. Checking the outputs between pulses catches a design that drops the closing sample or lets the latched totals drift.

// File: rtl/meter_pkg.sv
package meter_pkg;
  typedef enum logic [1:0] {
    EQ_ONE_ELEM = 2'd0,
    EQ_DIFF_HALF = 2'd1,
    EQ_TWO_ELEM = 2'd2,
    EQ_RSVD = 2'd3
  } eq_mode_e;

  localparam int NUM_TERMS = 5;
  localparam int T_ELEM0 = 0;
  localparam int T_ELEM1 = 1;
  localparam int T_ISQ0 = 2;
  localparam int T_ISQ1 = 3;
  localparam int T_POWER = 4;
endpackage

// File: rtl/meter_mapper.sv
module meter_mapper
  import meter_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int ACC_W = 48
) (
  input  logic signed [SMP_W-1:0]            va_i,
  input  logic signed [SMP_W-1:0]            vb_i,
  input  logic signed [SMP_W-1:0]            ia_i,
  input  logic signed [SMP_W-1:0]            ib_i,
  input  logic [1:0]                         eq_sel_i,
  output logic [NUM_TERMS-1:0][ACC_W-1:0]    terms_o
);
  localparam int DIF_W = SMP_W + 1;
  localparam int PRD_W = 2 * DIF_W;

  logic signed [DIF_W-1:0] va_x, vb_x, ia_x, ib_x, dif;
  logic signed [PRD_W-1:0] p_aa, p_ab, p_bb, p_ad, s_a, s_b, s_d;
  logic signed [PRD_W-1:0] e0, e1, q0, q1, tot;
  logic [NUM_TERMS-1:0][PRD_W-1:0] raw;
  eq_mode_e mode;

  assign mode = eq_mode_e'(eq_sel_i);

  always_comb begin
    va_x = {va_i[SMP_W-1], va_i};
    vb_x = {vb_i[SMP_W-1], vb_i};
    ia_x = {ia_i[SMP_W-1], ia_i};
    ib_x = {ib_i[SMP_W-1], ib_i};
    dif  = ia_x - ib_x;  // full 17-bit range, no wrap
    p_aa = va_x * ia_x;
    p_ab = va_x * ib_x;
    p_bb = vb_x * ib_x;
    p_ad = va_x * dif;
    s_a  = ia_x * ia_x;
    s_b  = ib_x * ib_x;
    s_d  = dif * dif;
  end

  always_comb begin
    unique case (mode)
      EQ_DIFF_HALF: begin
        e0 = p_ad >>> 1;
        e1 = p_ab >>> 1;
        q0 = s_d;
        q1 = s_b;
      end
      EQ_TWO_ELEM: begin
        e0 = p_aa;
        e1 = p_bb;
        q0 = s_a;
        q1 = s_b;
      end
      default: begin
        e0 = p_aa;
        e1 = p_ab;
        q0 = s_a;
        q1 = s_b;
      end
    endcase
    tot = (mode == EQ_TWO_ELEM) ? (e0 + e1) : e0;
  end

  assign raw[T_ELEM0] = e0;
  assign raw[T_ELEM1] = e1;
  assign raw[T_ISQ0]  = q0;
  assign raw[T_ISQ1]  = q1;
  assign raw[T_POWER] = tot;

  for (genvar k = 0; k < NUM_TERMS; k++) begin : g_sext
    assign terms_o[k] = {{(ACC_W-PRD_W){raw[k][PRD_W-1]}}, raw[k]};
  end
endmodule

// File: rtl/meter_interval.sv
module meter_interval #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             close_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   eff_len, nxt_cnt;

  assign eff_len = (len_i == '0) ? (CNT_W+1)'(1) : {1'b0, len_i};
  assign nxt_cnt = {1'b0, cnt_q} + (CNT_W+1)'(1);
  // >= so a length lowered mid-interval closes on the next sample
  assign close_o = strobe_i && (nxt_cnt >= eff_len);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (close_o)  cnt_q <= '0;
    else if (strobe_i) cnt_q <= nxt_cnt[CNT_W-1:0];
  end
endmodule

// File: rtl/meter_accum.sv
module meter_accum #(
  parameter int ACC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic             close_i,
  input  logic [ACC_W-1:0] term_i,
  output logic [ACC_W-1:0] sum_o
);
  logic [ACC_W-1:0] acc_q;

  assign sum_o = acc_q + term_i;  // total including the current sample

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (add_i)   acc_q <= close_i ? '0 : sum_o;
  end
endmodule

// File: rtl/metering_accum.sv
module metering_accum
  import meter_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int ACC_W = 48,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] va_i,
  input  logic [SMP_W-1:0] vb_i,
  input  logic [SMP_W-1:0] ia_i,
  input  logic [SMP_W-1:0] ib_i,
  input  logic [1:0]       eq_sel_i,
  input  logic [CNT_W-1:0] interval_len_i,
  output logic [ACC_W-1:0] elem0_sum_o,
  output logic [ACC_W-1:0] elem1_sum_o,
  output logic [ACC_W-1:0] isq0_sum_o,
  output logic [ACC_W-1:0] isq1_sum_o,
  output logic [ACC_W-1:0] power_sum_o,
  output logic             sum_valid_o
);
  logic [NUM_TERMS-1:0][ACC_W-1:0] terms, sums, sum_q;
  logic             close;
  logic [CNT_W-1:0] cnt;
  logic             valid_q;

  meter_mapper #(.SMP_W(SMP_W), .ACC_W(ACC_W)) mapper_i (
    .va_i     (va_i),
    .vb_i     (vb_i),
    .ia_i     (ia_i),
    .ib_i     (ib_i),
    .eq_sel_i (eq_sel_i),
    .terms_o  (terms)
  );

  meter_interval #(.CNT_W(CNT_W)) interval_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (smp_valid_i),
    .len_i    (interval_len_i),
    .close_o  (close),
    .cnt_o    (cnt)
  );

  for (genvar k = 0; k < NUM_TERMS; k++) begin : g_acc
    meter_accum #(.ACC_W(ACC_W)) accum_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .add_i   (smp_valid_i),
      .close_i (close),
      .term_i  (terms[k]),
      .sum_o   (sums[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= close;
      if (close) sum_q <= sums;
    end
  end

  assign elem0_sum_o = sum_q[T_ELEM0];
  assign elem1_sum_o = sum_q[T_ELEM1];
  assign isq0_sum_o  = sum_q[T_ISQ0];
  assign isq1_sum_o  = sum_q[T_ISQ1];
  assign power_sum_o = sum_q[T_POWER];
  assign sum_valid_o = valid_q;

  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |-> $past(smp_valid_i)); // R7
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |-> (cnt == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(cnt)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sum_valid_o |-> $stable(sum_q)); // R9
  AST_LEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && interval_len_i == '0) |=> sum_valid_o); // R10
  AST_SQ_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |-> (!terms[T_ISQ0][ACC_W-1] && !terms[T_ISQ1][ACC_W-1])); // R11
endmodule

// File: tb/metering_accum_tb.sv
module metering_accum_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic signed [15:0] va = '0, vb = '0, ia = '0, ib = '0;
  logic [1:0]  eq = '0;
  logic [15:0] len = 16'd1;
  logic [47:0] e0_o, e1_o, q0_o, q1_o, p_o;
  logic        vld_o;

  int n_chk = 0;
  int n_bad = 0;
  longint m[5];
  longint last[5];
  int cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  metering_accum dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(stb),
    .va_i(va), .vb_i(vb), .ia_i(ia), .ib_i(ib),
    .eq_sel_i(eq), .interval_len_i(len),
    .elem0_sum_o(e0_o), .elem1_sum_o(e1_o), .isq0_sum_o(q0_o),
    .isq1_sum_o(q1_o), .power_sum_o(p_o), .sum_valid_o(vld_o)
  );

  function automatic void calc(input longint a, b, c, d, input int code,
                               output longint t[5]);
    longint df = c - d;
    case (code)
      1: begin t[0] = (a*df) >>> 1; t[1] = (a*d) >>> 1; t[2] = df*df; t[3] = d*d; end
      2: begin t[0] = a*c; t[1] = b*d; t[2] = c*c; t[3] = d*d; end
      default: begin t[0] = a*c; t[1] = a*d; t[2] = c*c; t[3] = d*d; end
    endcase
    t[4] = (code == 2) ? t[0] + t[1] : t[0];
  endfunction

  function automatic longint outv(input int k);
    logic [47:0] r;
    case (k)
      0: r = e0_o; 1: r = e1_o; 2: r = q0_o; 3: r = q1_o; default: r = p_o;
    endcase
    return longint'($signed(r));
  endfunction

  task automatic chk(input longint act, exp, input string tag, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Called at a negedge: drive inputs, advance one cycle, check at next negedge.
  task automatic step(input bit s, input logic signed [15:0] a, b, c, d,
                      input int code, input int l);
    longint t[5];
    bit hit = 0;
    string tg;
    stb = s; va = a; vb = b; ia = c; ib = d; eq = 2'(code); len = 16'(l);
    if (s) begin
      calc(longint'(a), longint'(b), longint'(c), longint'(d), code, t);
      for (int k = 0; k < 5; k++) m[k] += t[k];
      cnt++;
      hit = (cnt >= ((l == 0) ? 1 : l));
    end
    @(negedge clk);
    case (code) 1: tg = "R3"; 2: tg = "R4"; 3: tg = "R5"; default: tg = "R2"; endcase
    if (hit) begin
      chk(longint'(vld_o), 1, (l == 0) ? "R10" : "R7", "valid on close");
      for (int k = 0; k < 4; k++) chk(outv(k), m[k], tg, $sformatf("sum%0d", k));
      chk(outv(4), m[4], "R6", "power sum");
      for (int k = 0; k < 5; k++) begin last[k] = m[k]; m[k] = 0; end
      cnt = 0;
    end else begin
      chk(longint'(vld_o), 0, s ? "R7" : "R8", "valid low");
      for (int k = 0; k < 5; k++) chk(outv(k), last[k], s ? "R9" : "R8", "held sum");
    end
  endtask

  function automatic logic signed [15:0] rsmp();
    int r = int'($urandom_range(0, 7));
    if (r == 0) return 16'sh8000;
    if (r == 1) return 16'sh7fff;
    return 16'($urandom);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int l;
    void'($urandom(32'd1357));
    for (int k = 0; k < 5; k++) begin m[k] = 0; last[k] = 0; end
    repeat (3) @(negedge clk);
    for (int k = 0; k < 5; k++) chk(outv(k), 0, "R1", "reset sum");
    chk(longint'(vld_o), 0, "R1", "reset valid");
    rst_n = 1'b1;
    @(negedge clk);
    // R3 full-scale difference 65535 and floor halving of negative odd product
    step(1, -16'sd32768, 0, 16'sd32767, -16'sd32768, 1, 1);
    step(1, 16'sd1, 0, -16'sd3, 16'sd0, 1, 1);
    step(1, 16'sd1, 0, 16'sd0, -16'sd3, 1, 1);
    // R4/R6 two elements at extremes
    step(1, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, 2, 1);
    // R5 reserved code, R2 normal
    step(1, 16'sd1000, 16'sd7, -16'sd200, 16'sd300, 3, 2);
    step(0, 0, 0, 0, 0, 0, 2);
    step(1, -16'sd5, 16'sd9, 16'sd11, -16'sd13, 0, 2);
    // R10 zero length, then length lowered mid-interval
    step(1, 16'sd3, 16'sd4, 16'sd5, 16'sd6, 2, 0);
    for (int i = 0; i < 5; i++) step(1, rsmp(), rsmp(), rsmp(), rsmp(), i % 4, 10);
    step(1, rsmp(), rsmp(), rsmp(), rsmp(), 1, 3);
    // random mix with gaps and per-sample code changes
    l = 4;
    for (int i = 0; i < 4000; i++) begin
      if (cnt == 0 && $urandom_range(0, 3) == 0) l = int'($urandom_range(0, 12));
      step($urandom_range(0, 3) != 0, rsmp(), rsmp(), rsmp(), rsmp(),
           int'($urandom_range(0, 3)), l);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule